// File: doc/BRIEF.md
# First-Word-Fall-Through FIFO with Registered Output

This block is a single-clock FIFO. It sits between a producer of data words and a consumer that uses a valid/ready handshake, such as the write-data channel of a memory-mapped bus master. The oldest stored word is always placed on a registered output before anyone asks for it. A consumer can therefore take the word in the same cycle it first sees it. A word is removed only when `rd_valid` and `rd_ready` are both high at a clock edge.

The output word comes from a flip-flop, never from the storage array's read path. A small prefetch stage keeps the next word ready behind the output register. On every handshake the output register is refilled from that stage, so a steady stream of reads sees no gaps. When the FIFO is empty, a new write goes straight into the output register. This avoids the stale-data problem of a plain FIFO with one cycle of read latency that is popped on the handshake.

Top module: `fwft_regout_fifo`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the FIFO. In the cycle after reset, `rd_valid` is 0 and `full` is 0, whatever was stored before.
- R2: A word written into an empty FIFO appears on `rd_data`, with `rd_valid` high, in the cycle right after the edge that accepted it.
- R3: `rd_valid` is 1 exactly when at least one accepted word has not yet been consumed.
- R4: While `rd_valid` is 1 and `rd_ready` is 0, the next cycle keeps `rd_valid` at 1 and leaves `rd_data` unchanged.
- R5: Words are consumed in the order they were accepted. Each word is consumed exactly once, for any pattern of `wr_en` and `rd_ready`.
- R6: When two or more words are held and a handshake occurs, `rd_valid` stays 1 in the next cycle, so there is no bubble.
- R7: `full` is 1 exactly when DEPTH words are held. A write while `full` is 1 is dropped, and the occupancy never exceeds DEPTH.
- R8: A write and a handshake at the same edge on a non-empty, non-full FIFO leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_data | input | DATA_W | Word offered by the producer |
| wr_en | input | 1 | Write request; taken when `full` is 0 |
| full | output | 1 | High when DEPTH words are held |
| rd_data | output | DATA_W | Registered head word |
| rd_valid | output | 1 | Head word present (FIFO not empty) |
| rd_ready | input | 1 | Consumer takes the head word when `rd_valid` is also high |

## Verification
A wrong occupancy count, or a wrong valid bit in the output or prefetch stage, shows up at the ports in the same or the next cycle. It appears as `rd_valid` disagreeing with the number of words still unconsumed, or as `full` rising one word early or late. A lost, duplicated or reordered word shows up on `rd_data` at its first handshake, when it is compared against the next expected word of a reference queue. A refill path that fails to prefetch shows up as a one-cycle drop of `rd_valid` during back-to-back reads while two or more words are held.

// File: rtl/fwft_fifo_pkg.sv
package fwft_fifo_pkg;

    // Where the output register takes its next word from
    typedef enum logic [1:0] {
        OSRC_HOLD = 2'd0,
        OSRC_MID  = 2'd1,
        OSRC_WR   = 2'd2,
        OSRC_NONE = 2'd3
    } out_src_e;

    // Where the prefetch register takes its next word from
    typedef enum logic [1:0] {
        MSRC_HOLD = 2'd0,
        MSRC_ARR  = 2'd1,
        MSRC_WR   = 2'd2,
        MSRC_NONE = 2'd3
    } mid_src_e;

endpackage

// File: rtl/fwft_fifo_store.sv
module fwft_fifo_store #(
    parameter int DATA_W = 16,
    parameter int ARR_D  = 6,
    parameter int PTR_W  = 3
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [ARR_D];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read word is captured by the prefetch register in the parent
    assign rdata = mem[raddr];

endmodule

// File: rtl/fwft_fifo_ptr.sv
module fwft_fifo_ptr #(
    parameter int ARR_D = 6,
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(ARR_D - 1);

    logic [PTR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv) begin
            ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/fwft_fifo_level.sv
module fwft_fifo_level #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic full
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             full_d, full_q;

    always_comb begin
        cnt_d  = cnt_q + CNT_W'(inc) - CNT_W'(dec);
        full_d = (cnt_d == TOP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            full_q <= full_d;
        end
    end

    assign full = full_q;

endmodule

// File: rtl/fwft_regout_fifo.sv
module fwft_regout_fifo
    import fwft_fifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8     // total words held, at least 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    output logic              full,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              rd_ready
);

    // Two words live in the output and prefetch registers
    localparam int ARR_D  = DEPTH - 2;
    localparam int PTR_W  = (ARR_D > 1) ? $clog2(ARR_D) : 1;
    localparam int ACNT_W = $clog2(ARR_D + 1);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              out_vld;
        logic [DATA_W-1:0] out_dat;
        logic              mid_vld;
        logic [DATA_W-1:0] mid_dat;
        logic [ACNT_W-1:0] arr_cnt;
    } stage_t;

    stage_t st_d, st_q;

    logic              pop, wr_acc, out_free, mid_goes, mid_free, arr_empty;
    logic              arr_wr, arr_rd;
    out_src_e          out_src;
    mid_src_e          mid_src;
    logic [PTR_W-1:0]  wptr, rptr;
    logic [DATA_W-1:0] arr_rdata;

    fwft_fifo_store #(
        .DATA_W (DATA_W),
        .ARR_D  (ARR_D),
        .PTR_W  (PTR_W)
    ) u_store (
        .clk   (clk),
        .we    (arr_wr),
        .waddr (wptr),
        .wdata (wr_data),
        .raddr (rptr),
        .rdata (arr_rdata)
    );

    fwft_fifo_ptr #(.ARR_D(ARR_D), .PTR_W(PTR_W)) u_wptr (
        .clk (clk), .rst (rst), .adv (arr_wr), .ptr (wptr)
    );

    fwft_fifo_ptr #(.ARR_D(ARR_D), .PTR_W(PTR_W)) u_rptr (
        .clk (clk), .rst (rst), .adv (arr_rd), .ptr (rptr)
    );

    fwft_fifo_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
        .clk  (clk),
        .rst  (rst),
        .inc  (wr_acc),
        .dec  (pop),
        .full (full)
    );

    always_comb begin
        st_d      = st_q;
        pop       = st_q.out_vld & rd_ready;
        wr_acc    = wr_en & ~full;
        arr_empty = (st_q.arr_cnt == '0);
        out_free  = ~st_q.out_vld | pop;
        mid_goes  = out_free & st_q.mid_vld;
        mid_free  = ~st_q.mid_vld | mid_goes;

        // Output register: prefetch word first, then a write that can bypass
        if (!out_free) begin
            out_src = OSRC_HOLD;
        end else if (st_q.mid_vld) begin
            out_src = OSRC_MID;
        end else if (wr_acc && arr_empty) begin
            out_src = OSRC_WR;
        end else begin
            out_src = OSRC_NONE;
        end

        // Prefetch register: array head first, then a bypassing write
        if (!mid_free) begin
            mid_src = MSRC_HOLD;
        end else if (!arr_empty) begin
            mid_src = MSRC_ARR;
        end else if (wr_acc && (out_src != OSRC_WR)) begin
            mid_src = MSRC_WR;
        end else if (mid_goes) begin
            mid_src = MSRC_NONE;
        end else begin
            mid_src = MSRC_HOLD;
        end

        arr_rd = (mid_src == MSRC_ARR);
        arr_wr = wr_acc && (out_src != OSRC_WR) && (mid_src != MSRC_WR);

        unique case (out_src)
            OSRC_MID: begin
                st_d.out_vld = 1'b1;
                st_d.out_dat = st_q.mid_dat;
            end
            OSRC_WR: begin
                st_d.out_vld = 1'b1;
                st_d.out_dat = wr_data;
            end
            OSRC_NONE: begin
                st_d.out_vld = 1'b0;
            end
            default: ;
        endcase

        unique case (mid_src)
            MSRC_ARR: begin
                st_d.mid_vld = 1'b1;
                st_d.mid_dat = arr_rdata;
            end
            MSRC_WR: begin
                st_d.mid_vld = 1'b1;
                st_d.mid_dat = wr_data;
            end
            MSRC_NONE: begin
                st_d.mid_vld = 1'b0;
            end
            default: ;
        endcase

        st_d.arr_cnt = st_q.arr_cnt + ACNT_W'(arr_wr) - ACNT_W'(arr_rd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.out_dat;
    assign rd_valid = st_q.out_vld;

endmodule

// File: rtl/fwft_regout_fifo_chk.sv
module fwft_regout_fifo_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_en,
    input logic              full,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              rd_ready
);

    localparam int MW = $clog2(DEPTH + 1) + 1;

    // Occupancy as seen from the ports
    logic [MW-1:0] occ;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
        end else begin
            occ <= occ + MW'(wr_en && !full) - MW'(rd_valid && rd_ready);
        end
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_valid && !full));                          // R1

    AST_FIRST_WORD: assert property (@(posedge clk) disable iff (rst)
        (!rd_valid && wr_en && !full) |=>
            (rd_valid && rd_data == $past(wr_data)));                 // R2

    AST_VALID_OCC: assert property (@(posedge clk) disable iff (rst)
        rd_valid == (occ != '0));                                      // R3

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));   // R4

    AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready && occ >= MW'(2)) |=> rd_valid);         // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (occ <= MW'(DEPTH)) && (full == (occ == MW'(DEPTH))));         // R7

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready && wr_en && !full) |=> !full);           // R8

endmodule

bind fwft_regout_fifo fwft_regout_fifo_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_data  (wr_data),
    .wr_en    (wr_en),
    .full     (full),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready)
);

// File: tb/fwft_regout_fifo_test.sv
`timescale 1ns/1ps
module fwft_regout_fifo_test;

    localparam int DATA_W = 8;
    localparam int DEPTH  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_en = 1'b0;
    logic              full;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;
    logic              rd_ready = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    logic [DATA_W-1:0] mq[$];
    logic [DATA_W-1:0] next_val = 8'h01;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fwft_regout_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
        .clk      (clk),
        .rst      (rst),
        .wr_data  (wr_data),
        .wr_en    (wr_en),
        .full     (full),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .rd_ready (rd_ready)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare ports to the reference queue, then drive one cycle
    task automatic step(input logic w, input logic r);
        bit push, pop;
        chk(rd_valid === (mq.size() > 0), "R3 valid vs occupancy",
            32'(rd_valid), 32'(mq.size() > 0));
        chk(full === (mq.size() == DEPTH), "R7 full flag",
            32'(full), 32'(mq.size() == DEPTH));
        if (mq.size() > 0) begin
            chk(rd_data === mq[0], "R5 order", 32'(rd_data), 32'(mq[0]));
        end
        wr_en    = w;
        rd_ready = r;
        wr_data  = next_val;
        pop  = r && (mq.size() > 0);
        push = w && (mq.size() < DEPTH);
        @(posedge clk);
        if (pop) begin
            void'(mq.pop_front());
        end
        if (push) begin
            mq.push_back(wr_data);
            next_val = next_val + 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        wr_en    = 1'b0;
        rd_ready = 1'b0;
        rst      = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mq.delete();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        do_reset();
        // R1: empty after reset
        chk(rd_valid === 1'b0, "R1 valid after reset", 32'(rd_valid), 0);
        chk(full === 1'b0, "R1 full after reset", 32'(full), 0);

        // R2: first word visible one cycle after the write
        step(1'b1, 1'b0);
        chk(rd_valid === 1'b1, "R2 first word valid", 32'(rd_valid), 1);
        chk(rd_data === mq[0], "R2 first word data", 32'(rd_data), 32'(mq[0]));

        // R4: word held under back-pressure
        step(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            logic [DATA_W-1:0] seen;
            seen = rd_data;
            step(1'b0, 1'b0);
            chk(rd_valid === 1'b1 && rd_data === seen, "R4 hold",
                32'(rd_data), 32'(seen));
        end

        // R8: simultaneous write and read keeps occupancy (2 words)
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        chk(full === 1'b0, "R8 one slot left", 32'(full), 0);
        step(1'b1, 1'b0);
        chk(full === 1'b1, "R8 full after two more", 32'(full), 1);

        // R7: writes while full are dropped
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b0);
        end
        chk(full === 1'b1, "R7 still full", 32'(full), 1);

        // R6: back-to-back reads drain with no bubble
        for (int i = 0; i < DEPTH; i++) begin
            bit many;
            many = (mq.size() >= 2);
            step(1'b0, 1'b1);
            if (many) begin
                chk(rd_valid === 1'b1, "R6 no bubble", 32'(rd_valid), 1);
            end
        end
        chk(rd_valid === 1'b0, "R3 empty after drain", 32'(rd_valid), 0);

        // R1: reset while holding words
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        do_reset();
        chk(rd_valid === 1'b0 && full === 1'b0, "R1 reset clears contents",
            32'({rd_valid, full}), 0);

        // R5: every 4-cycle write mask against every 4-cycle ready mask
        for (int pat = 0; pat < 256; pat++) begin
            logic [3:0] wm, rm;
            wm = pat[3:0];
            rm = pat[7:4];
            for (int c = 0; c < 12; c++) begin
                step(wm[c % 4], rm[c % 4]);
            end
            while (mq.size() > 0) begin
                step(1'b0, 1'b1);
            end
            step(1'b0, 1'b0);
        end

        done = 1'b1;
        finish_run();
    end

endmodule